// File: doc/BRIEF.md
# Floating-Point Operand Unpacker

This block takes one IEEE-754 operand, either single or double precision, and turns it into a wide working record for later floating-point stages. The record holds a class code, a sign, an unbiased signed exponent, a 128-bit mantissa and a sticky flag. In the mantissa the integer one sits at bit 114, the fraction lies directly below it, and the two lowest bits are guard and round. Subnormal operands are shifted up until they are normalized. Downstream logic therefore only ever receives a finite nonzero value whose mantissa lies in [1.0, 2.0). Zero, infinity and the two kinds of NaN are marked by the class code, not by special bit patterns.

Operands arrive on a valid/ready stream and leave on another valid/ready stream. One register stage sits between them. An operand is taken on a rising clock edge when `in_valid` and `in_ready` are both high, and its record is presented on the next cycle. The input is ready whenever the output register is empty or is being drained in the same cycle, so `in_ready = !out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the record stays frozen. A producer must hold `in_valid` and its data steady until the operand is taken.

Top module: `fp_unpack`

## Requirements
- R1: An operand accepted on an edge (`in_valid && in_ready`) appears with `out_valid` high from the next edge on. Latency is one cycle.
- R2: `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, the output record and `out_valid` stay unchanged.
- R3: `out_class` is a 3-bit two's-complement code: signalling NaN 3'b110 (-2), quiet NaN 3'b111 (-1), zero 3'b000, finite number 3'b001, infinity 3'b010. No other code ever appears.
- R4: A normal operand gives class 3'b001 and exponent = biased field − bias. The bias is 127 for single and 1023 for double. The mantissa has bit 114 set, the fraction left-aligned at bits 113 downward, and every other bit zero.
- R5: A subnormal operand gives class 3'b001. Its fraction is shifted left until its top one reaches bit 114. The exponent is (1 − bias) minus the shift, so the smallest double subnormal gives −1074 and the smallest single subnormal gives −149.
- R6: An operand with an all-ones exponent field and a nonzero fraction is a NaN. It is quiet (3'b111) when the top fraction bit is 1 and signalling (3'b110) otherwise. Its mantissa holds bit 114 set plus the payload fraction, left-aligned, and its exponent is 0.
- R7: `out_sign` equals the operand's sign bit for every class.
- R8: `out_sticky` is 0 on every record.
- R9: `in_fmt` = 0 selects single precision from `in_data[31:0]`, and `in_data[63:32]` is ignored. `in_fmt` = 1 selects double precision from all 64 bits.
- R10: Zero (class 3'b000) and infinity (class 3'b010) carry an all-zero mantissa and an exponent of 0.
- R11: During and right after reset `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_fmt | input | 1 | 0 = single, 1 = double |
| in_data | input | 64 | Packed operand |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Consumer takes the record this cycle |
| out_class | output | 3 | Class code (R3) |
| out_sign | output | 1 | Sign, 1 = negative |
| out_exp | output | 16 | Unbiased exponent, two's complement |
| out_mant | output | 128 | Mantissa, integer one at bit 114 |
| out_sticky | output | 1 | Sticky flag, always 0 |

## Verification
A wrong leading-zero count or a wrong bias shows up in the very record that the operand produces. It appears one cycle after acceptance, as a mantissa whose top one is not at bit 114 or as an exponent that is off. A mistake in the hold/ready logic shows up within one stalled cycle, either as a record that changes while `out_ready` is low or as an operand that is lost or duplicated in the output sequence. The reference model predicts every record and `in_ready` on every cycle, so any such fault is caught on the cycle it reaches the ports.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;
  localparam int MANT_W     = 128;
  localparam int LEAD_POS   = 114;
  localparam int EXP_W      = 16;
  localparam int DATA_W     = 64;
  localparam int SGL_FRAC_W = 23;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_BIAS   = 127;
  localparam int DBL_FRAC_W = 52;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_BIAS   = 1023;
  localparam int WFRAC_W    = DBL_FRAC_W;
  localparam int WEXP_W     = DBL_EXP_W;
  localparam int LZ_W       = $clog2(WFRAC_W);

  typedef logic [2:0] cls_t;
  localparam cls_t CLS_SNAN = 3'b110;
  localparam cls_t CLS_QNAN = 3'b111;
  localparam cls_t CLS_ZERO = 3'b000;
  localparam cls_t CLS_NUM  = 3'b001;
  localparam cls_t CLS_INF  = 3'b010;
endpackage

// File: rtl/fpu_unpack_field.sv
module fpu_unpack_field
  import fpu_unpack_pkg::*;
(
  input  logic                     fmt,
  input  logic [DATA_W-1:0]        data,
  output logic                     sign,
  output logic [WEXP_W-1:0]        bexp,
  output logic [WFRAC_W-1:0]       frac,
  output logic                     exp_zero,
  output logic                     exp_max,
  output logic signed [EXP_W-1:0]  bias
);
  localparam int SGL_SIGN = SGL_FRAC_W + SGL_EXP_W;
  localparam int DBL_SIGN = DBL_FRAC_W + DBL_EXP_W;
  localparam int PAD_W    = WFRAC_W - SGL_FRAC_W;

  always_comb begin
    if (fmt) begin
      sign    = data[DBL_SIGN];
      bexp    = data[DBL_SIGN-1:DBL_FRAC_W];
      frac    = data[DBL_FRAC_W-1:0];
      exp_max = &data[DBL_SIGN-1:DBL_FRAC_W];
      bias    = EXP_W'(DBL_BIAS);
    end else begin
      sign    = data[SGL_SIGN];
      bexp    = WEXP_W'(data[SGL_SIGN-1:SGL_FRAC_W]);
      frac    = {data[SGL_FRAC_W-1:0], {PAD_W{1'b0}}};
      exp_max = &data[SGL_SIGN-1:SGL_FRAC_W];
      bias    = EXP_W'(SGL_BIAS);
    end
    exp_zero = (bexp == '0);
  end
endmodule

// File: rtl/fpu_unpack_lzc.sv
module fpu_unpack_lzc #(
  parameter int W   = 52,
  parameter int C_W = $clog2(W)
) (
  input  logic [W-1:0]   vec,
  output logic [C_W-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = C_W'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpu_unpack_core.sv
module fpu_unpack_core
  import fpu_unpack_pkg::*;
(
  input  logic [WEXP_W-1:0]        bexp,
  input  logic [WFRAC_W-1:0]       frac,
  input  logic                     exp_zero,
  input  logic                     exp_max,
  input  logic signed [EXP_W-1:0]  bias,
  input  logic [LZ_W-1:0]          lz,
  output cls_t                     cls,
  output logic signed [EXP_W-1:0]  uexp,
  output logic [MANT_W-1:0]        mant
);
  localparam int TOP_W = MANT_W - LEAD_POS - 1;
  localparam int LOW_W = LEAD_POS - WFRAC_W;

  logic                 frac_nz;
  logic [WFRAC_W-1:0]   shifted;
  logic [WFRAC_W-1:0]   sub_frac;

  assign frac_nz  = |frac;
  assign shifted  = frac << lz;
  assign sub_frac = {shifted[WFRAC_W-2:0], 1'b0};

  always_comb begin
    cls  = CLS_ZERO;
    uexp = '0;
    mant = '0;
    if (exp_max) begin
      if (frac_nz) begin
        cls  = frac[WFRAC_W-1] ? CLS_QNAN : CLS_SNAN;
        mant = {{TOP_W{1'b0}}, 1'b1, frac, {LOW_W{1'b0}}};
      end else begin
        cls = CLS_INF;
      end
    end else if (exp_zero) begin
      if (frac_nz) begin
        cls  = CLS_NUM;
        uexp = -bias - $signed(EXP_W'(lz));
        mant = {{TOP_W{1'b0}}, 1'b1, sub_frac, {LOW_W{1'b0}}};
      end
    end else begin
      cls  = CLS_NUM;
      uexp = $signed(EXP_W'(bexp)) - bias;
      mant = {{TOP_W{1'b0}}, 1'b1, frac, {LOW_W{1'b0}}};
    end
  end
endmodule

// File: rtl/fp_unpack.sv
module fp_unpack
  import fpu_unpack_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_fmt,
  input  logic [DATA_W-1:0]        in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [2:0]               out_class,
  output logic                     out_sign,
  output logic signed [EXP_W-1:0]  out_exp,
  output logic [MANT_W-1:0]        out_mant,
  output logic                     out_sticky
);
  logic                     f_sign, f_zero, f_max;
  logic [WEXP_W-1:0]        f_bexp;
  logic [WFRAC_W-1:0]       f_frac;
  logic signed [EXP_W-1:0]  f_bias;
  logic [LZ_W-1:0]          f_lz;
  cls_t                     c_cls;
  logic signed [EXP_W-1:0]  c_exp;
  logic [MANT_W-1:0]        c_mant;

  fpu_unpack_field u_field (
    .fmt(in_fmt), .data(in_data), .sign(f_sign), .bexp(f_bexp),
    .frac(f_frac), .exp_zero(f_zero), .exp_max(f_max), .bias(f_bias)
  );

  fpu_unpack_lzc #(.W(WFRAC_W), .C_W(LZ_W)) u_lzc (
    .vec(f_frac), .cnt(f_lz)
  );

  fpu_unpack_core u_core (
    .bexp(f_bexp), .frac(f_frac), .exp_zero(f_zero), .exp_max(f_max),
    .bias(f_bias), .lz(f_lz), .cls(c_cls), .uexp(c_exp), .mant(c_mant)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_class  <= CLS_ZERO;
      out_sign   <= 1'b0;
      out_exp    <= '0;
      out_mant   <= '0;
      out_sticky <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_class  <= c_cls;
        out_sign   <= f_sign;
        out_exp    <= c_exp;
        out_mant   <= c_mant;
        out_sticky <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fpu_unpack_chk.sv
module fpu_unpack_chk
  import fpu_unpack_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [2:0]               out_class,
  input logic                     out_sign,
  input logic signed [EXP_W-1:0]  out_exp,
  input logic [MANT_W-1:0]        out_mant,
  input logic                     out_sticky
);
  a_r1_accept_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r2_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_mant) && $stable(out_exp)
      && $stable(out_class) && $stable(out_sign));

  a_r2_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r3_legal_class: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_class == CLS_SNAN || out_class == CLS_QNAN || out_class == CLS_ZERO
      || out_class == CLS_NUM || out_class == CLS_INF));

  a_r4_num_lead_one: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == CLS_NUM |-> out_mant[LEAD_POS]
      && out_mant[MANT_W-1:LEAD_POS+1] == '0 && out_mant[1:0] == 2'b00);

  a_r6_nan_quiet_bit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_class == CLS_QNAN || out_class == CLS_SNAN)
      |-> out_mant[LEAD_POS] && (out_mant[LEAD_POS-1] == (out_class == CLS_QNAN)));

  a_r8_no_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_sticky);

  a_r10_zero_inf_empty: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_class == CLS_ZERO || out_class == CLS_INF)
      |-> out_mant == '0 && out_exp == '0);
endmodule

bind fp_unpack fpu_unpack_chk u_chk (.*);

// File: tb/sim_fp_unpack.sv
`timescale 1ns/1ps
module sim_fp_unpack;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_fmt = 1'b0, out_ready = 1'b0;
  logic [63:0] in_data = '0;
  logic in_ready, out_valid, out_sign, out_sticky;
  logic [2:0] out_class;
  logic signed [15:0] out_exp;
  logic [127:0] out_mant;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fp_unpack u0 (.*);

  bit          q_fmt[$];
  logic [63:0] q_data[$];
  string       q_tag[$];

  bit m_valid = 0;
  logic [2:0] m_cls;
  logic m_sign;
  logic signed [15:0] m_exp;
  logic [127:0] m_mant;
  string m_tag;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic void ref_unpack(input bit fmt, input logic [63:0] d,
      output logic [2:0] c, output logic s, output logic signed [15:0] e,
      output logic [127:0] m);
    int fw, bias, ef, emax, x;
    logic [63:0] fr;
    if (fmt) begin
      fw = 52; bias = 1023; emax = 2047; s = d[63]; ef = int'(d[62:52]); fr = 64'(d[51:0]);
    end else begin
      fw = 23; bias = 127; emax = 255; s = d[31]; ef = int'(d[30:23]); fr = 64'(d[22:0]);
    end
    m = '0; e = '0; c = 3'b000;
    if (ef == emax) begin
      if (fr == 0) c = 3'b010;
      else begin
        c = fr[fw-1] ? 3'b111 : 3'b110;
        m = (128'(fr) << (114 - fw)) | (128'd1 << 114);
      end
    end else if (ef == 0) begin
      if (fr != 0) begin
        c = 3'b001;
        m = 128'(fr) << (114 - fw);
        x = 1 - bias;
        while (!m[114]) begin m = m << 1; x--; end
        e = 16'(x);
      end
    end else begin
      c = 3'b001;
      m = (128'(fr) << (114 - fw)) | (128'd1 << 114);
      e = 16'(ef - bias);
    end
  endfunction

  task automatic push(input bit f, input logic [63:0] d, input string t);
    q_fmt.push_back(f); q_data.push_back(d); q_tag.push_back(t);
  endtask

  task automatic run_stream(input int stall_pct);
    bit fire;
    while (q_data.size() != 0 || in_valid || m_valid) begin
      @(negedge clk);
      if (!in_valid && q_data.size() != 0 && $urandom_range(0, 99) >= 20) begin
        in_fmt = q_fmt.pop_front(); in_data = q_data.pop_front();
        m_tag = m_tag; q_tag.push_front(q_tag.pop_front());
        in_valid = 1'b1;
      end
      out_ready = ($urandom_range(0, 99) >= stall_pct);
      #1;
      chk(out_valid == m_valid, "R1", "out_valid", 128'(out_valid), 128'(m_valid));
      chk(in_ready == (!m_valid || out_ready), "R2", "in_ready",
          128'(in_ready), 128'(!m_valid || out_ready));
      if (m_valid) begin
        chk(out_class == m_cls, m_tag, "class(R3)", 128'(out_class), 128'(m_cls));
        chk(out_sign == m_sign, "R7", "sign", 128'(out_sign), 128'(m_sign));
        chk(out_exp == m_exp, m_tag, "exp", 128'(out_exp), 128'(m_exp));
        chk(out_mant == m_mant, m_tag, "mant", out_mant, m_mant);
        chk(out_sticky == 1'b0, "R8", "sticky", 128'(out_sticky), 128'd0);
      end
      fire = in_valid && (!m_valid || out_ready);
      if (fire) begin
        ref_unpack(in_fmt, in_data, m_cls, m_sign, m_exp, m_mant);
        m_tag = q_tag.pop_front();
        m_valid = 1;
        @(posedge clk);
        #0 in_valid = 1'b0;
      end else if (out_ready) begin
        m_valid = 0;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R11", "out_valid in reset", 128'(out_valid), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11", "out_valid after reset", 128'(out_valid), 128'd0);
    chk(in_ready == 1'b1, "R2", "in_ready when empty", 128'(in_ready), 128'd1);

    push(0, 64'h0000_0000_3F80_0000, "R4");
    push(0, 64'hDEAD_BEEF_3F80_0000, "R9");
    push(0, 64'h0000_0000_7F7F_FFFF, "R4");
    push(0, 64'h0000_0000_0080_0000, "R4");
    push(0, 64'h0000_0000_0000_0001, "R5");
    push(0, 64'h0000_0000_0040_0000, "R5");
    push(0, 64'h0000_0000_8000_0000, "R10");
    push(0, 64'h0000_0000_7F80_0000, "R10");
    push(0, 64'h0000_0000_FF80_0000, "R10");
    push(0, 64'h0000_0000_7FC0_0001, "R6");
    push(0, 64'h0000_0000_7F80_0001, "R6");
    push(1, 64'h3FF0_0000_0000_0000, "R4");
    push(1, 64'hC000_0000_0000_0000, "R4");
    push(1, 64'h0000_0000_0000_0001, "R5");
    push(1, 64'h000F_FFFF_FFFF_FFFF, "R5");
    push(1, 64'h8000_0000_0000_0000, "R10");
    push(1, 64'h7FF0_0000_0000_0000, "R10");
    push(1, 64'h7FF8_0000_0000_0000, "R6");
    push(1, 64'hFFF0_0000_0000_0001, "R6");
    push(1, 64'h0000_0000_3F80_0000, "R9");
    run_stream(10);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: d[62:52] = '0;
        1: d[30:23] = '0;
        2: d[30:23] = '1;
        default: ;
      endcase
      push(1'($urandom_range(0, 1)), d, "R3");
    end
    run_stream(40);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule